// File: doc/BRIEF.md
# Multi-Waveform Setpoint Generator

This block produces the command stream that a closed-loop servo actuator follows. On each cycle where the control tick is high it emits one signed 16-bit sample, already in raw converter counts. A 4-bit mode select picks one of nine behaviours. Three are static or slewed: hold an idle level, hold a fixed set point, or ramp toward a target at a programmed rate. Six are periodic shapes: sine, square and triangle, each swinging about a mean level, and their one-sided variants, which rise from the mean and never fall below it.

All periodic shapes share one phase accumulator that adds a frequency increment on every tick, and one output multiplexer. Amplitude, mean, increment, levels and ramp parameters are plain inputs that software loads. A change of mode is held back until the running waveform completes a period, so a periodic output never jumps mid-cycle. A request for idle is the exception and takes effect on the next tick. Every result saturates to the signed 16-bit range.

Top module: `spgen_top`

## Requirements
- R1: While rst_n is low, sp_out is 0, act_mode is 0 (idle) and the phase accumulator is 0.
- R2: sp_out, act_mode and the phase change only on a rising clock edge where tick is high; on other cycles they keep their values whatever the other inputs do.
- R3: mode_sel codes are 0 idle, 1 set point, 2 ramp, 3 sine, 4 square, 5 triangle, 6 one-sided sine, 7 one-sided square, 8 one-sided triangle; codes 9 to 15 act as idle. act_mode reports the code of the mode in effect.
- R4: The 32-bit phase P gains freq_inc modulo 2^32 on each tick. In sine mode sp_out = sat(mean + floor(amp*S/2^15)), with amp unsigned. With T(x) = floor(32767*x*(128-x)/4096), q = P[31:30] and i = P[29:24], S is T(i), T(63-i), -T(i), -T(63-i) for q = 0, 1, 2, 3.
- R5: Square uses S = +32767 when P[31] is 0, else -32767. Triangle takes r = P[30:16] and m = 2r when r < 16384, else 32767 - 2(r - 16384); S = m when P[31] is 0, else -m. Both use the same scaling as R4.
- R6: The one-sided modes evaluate the matching base shape B at phase P + 2^30 (mod 2^32), form H = (32767 - B)/2 and output sat(mean + floor(amp*H/2^15)); the output is never below mean.
- R7: Idle mode outputs idle_lvl and set-point mode outputs hold_lvl, each sampled at the tick.
- R8: Ramp mode moves the previous sp_out toward ramp_tgt by ramp_rate (unsigned) per tick and stops exactly on ramp_tgt without overshoot.
- R9: A new mode takes effect on a tick when it is idle, or when the mode in effect is idle, set point or ramp (the phase then restarts at 0 for that tick), or when the accumulator carries out of bit 31 on that tick; otherwise the old mode continues.
- R10: Any result above 32767 gives 32767 and any result below -32768 gives -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Control tick; one output sample per high cycle |
| mode_sel | input | 4 | Requested mode code |
| amp | input | 16 | Amplitude in counts, unsigned |
| mean | input | 16 | Mean level of periodic shapes, signed |
| freq_inc | input | 32 | Phase increment per tick |
| idle_lvl | input | 16 | Output level in idle mode, signed |
| hold_lvl | input | 16 | Output level in set-point mode, signed |
| ramp_tgt | input | 16 | Ramp target, signed |
| ramp_rate | input | 16 | Ramp step per tick, unsigned |
| sp_out | output | 16 | Setpoint sample, signed |
| act_mode | output | 4 | Code of the mode in effect |

## Verification
A sine run with an increment of 2^24 visits every table entry in every quadrant, so a wrong mirror, sign or table formula shows up at a specific phase. Square, triangle and the one-sided shapes run with odd increments, which land on unaligned phases and split the half and quarter decisions and the quarter-period shift. Mode requests made mid-period, just before a wrap and from the static modes tell a gate that waits for the carry apart from one that switches at once or never. Ramps in both directions end exactly on the target, and an extreme amplitude with a large mean drives both saturation limits.

// File: rtl/spgen_pkg.sv
package spgen_pkg;

  typedef enum logic [3:0] {
    M_IDLE    = 4'd0,
    M_SETPT   = 4'd1,
    M_RAMP    = 4'd2,
    M_SINE    = 4'd3,
    M_SQUARE  = 4'd4,
    M_TRI     = 4'd5,
    M_HSINE   = 4'd6,
    M_HSQUARE = 4'd7,
    M_HTRI    = 4'd8
  } mode_e;

  localparam int unsigned MODE_LAST = 8;

  // Unlisted codes fall back to idle.
  function automatic mode_e to_mode(input logic [3:0] code);
    return (code > 4'(MODE_LAST)) ? M_IDLE : mode_e'(code);
  endfunction

  function automatic logic is_periodic(input mode_e m);
    return m inside {M_SINE, M_SQUARE, M_TRI, M_HSINE, M_HSQUARE, M_HTRI};
  endfunction

  function automatic logic is_haver(input mode_e m);
    return m inside {M_HSINE, M_HSQUARE, M_HTRI};
  endfunction

endpackage

// File: rtl/spgen_phase.sv
module spgen_phase #(
  parameter int PW = 32,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] inc,
  input  logic          clear,
  output logic          wrap,
  output logic [HW-1:0] ph_head
);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] sum;
  logic [PW-1:0] ph_next;

  // Carry out of the top bit marks the end of a period.
  assign {wrap, sum} = {1'b0, phase_q} + {1'b0, inc};
  assign ph_next     = clear ? '0 : sum;
  assign ph_head     = ph_next[PW-1 -: HW];

  always_ff @(posedge clk) begin
    if (!rst_n)     phase_q <= '0;
    else if (tick)  phase_q <= ph_next;
  end

  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q)); // R2

endmodule

// File: rtl/spgen_mode.sv
module spgen_mode
  import spgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] sel,
  input  logic       wrap,
  output mode_e      mode_q,
  output mode_e      mode_nxt,
  output logic       clear_ph
);

  mode_e req;
  logic  change_ok;
  logic  do_switch;

  assign req       = to_mode(sel);
  assign change_ok = (req == M_IDLE) || !is_periodic(mode_q) || wrap;
  assign do_switch = tick && (req != mode_q) && change_ok;
  assign mode_nxt  = do_switch ? req : mode_q;
  // Leaving a static mode restarts the waveform at phase zero.
  assign clear_ph  = do_switch && !is_periodic(mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= M_IDLE;
    else if (tick)  mode_q <= mode_nxt;
  end

  AST_IDLE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && to_mode(sel) == M_IDLE) |=> (mode_q == M_IDLE)); // R9

  AST_WAIT_FOR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && is_periodic(mode_q) && to_mode(sel) != M_IDLE && !wrap)
      |=> $stable(mode_q)); // R9

  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mode_q)); // R2

endmodule

// File: rtl/spgen_shape.sv
module spgen_shape
  import spgen_pkg::*;
#(
  parameter int DW = 16,
  parameter int QB = 6
) (
  input  logic [DW-1:0]        ph,
  input  mode_e                mode,
  output logic signed [DW-1:0] unit
);

  localparam int NQ = 1 << QB;
  localparam int FS = (1 << (DW - 1)) - 1;
  localparam logic [DW-1:0] QTR = {2'b01, {(DW-2){1'b0}}};

  // Parabolic quarter-wave point, rising from 0 to almost full scale.
  function automatic longint quarter_point(input int x);
    return (longint'(FS) * longint'(x) * longint'(2 * NQ - x)) / longint'(NQ * NQ);
  endfunction

  logic [DW-2:0] lut [NQ];

  for (genvar gi = 0; gi < NQ; gi++) begin : g_lut
    assign lut[gi] = (DW-1)'(quarter_point(gi));
  end

  logic                 haver;
  logic [DW-1:0]        ph_eval;
  logic [QB-1:0]        idx;
  logic [QB-1:0]        addr;
  logic [DW-2:0]        mag;
  logic signed [DW-1:0] sine_v;
  logic [DW-3:0]        low;
  logic [DW-2:0]        twice;
  logic [DW-2:0]        tri_mag;
  logic signed [DW-1:0] tri_v;
  logic signed [DW-1:0] sq_v;
  logic signed [DW-1:0] base;
  logic signed [DW:0]   lift;

  assign haver   = is_haver(mode);
  // One-sided shapes start from the trough of a cosine-like wave.
  assign ph_eval = haver ? (ph + QTR) : ph;

  assign idx    = ph_eval[DW-3 -: QB];
  assign addr   = ph_eval[DW-2] ? ~idx : idx;
  assign mag    = lut[addr];
  assign sine_v = ph_eval[DW-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  assign low     = ph_eval[DW-3:0];
  assign twice   = {low, 1'b0};
  assign tri_mag = ph_eval[DW-2] ? ((DW-1)'(FS) - twice) : twice;
  assign tri_v   = ph_eval[DW-1] ? -$signed({1'b0, tri_mag}) : $signed({1'b0, tri_mag});

  assign sq_v = ph_eval[DW-1] ? -(DW)'(FS) : (DW)'(FS);

  always_comb begin
    unique case (mode)
      M_SINE,   M_HSINE:   base = sine_v;
      M_SQUARE, M_HSQUARE: base = sq_v;
      M_TRI,    M_HTRI:    base = tri_v;
      default:             base = '0;
    endcase
  end

  assign lift = $signed({2'b00, {(DW-1){1'b1}}}) - $signed({base[DW-1], base});
  assign unit = haver ? $signed(lift[DW:1]) : base;

endmodule

// File: rtl/spgen_out.sv
module spgen_out
  import spgen_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  mode_e                mode,
  input  logic signed [DW-1:0] unit,
  input  logic        [DW-1:0] amp,
  input  logic signed [DW-1:0] mean,
  input  logic signed [DW-1:0] idle_lvl,
  input  logic signed [DW-1:0] hold_lvl,
  input  logic signed [DW-1:0] ramp_tgt,
  input  logic        [DW-1:0] ramp_rate,
  output logic signed [DW-1:0] sp_q
);

  localparam int XW = DW + 3;
  localparam longint MAXV = (longint'(1) << (DW - 1)) - 1;
  localparam longint MINV = -(longint'(1) << (DW - 1));

  function automatic logic signed [DW-1:0] clamp(input logic signed [XW-1:0] v);
    if (v > XW'(MAXV))      return DW'(MAXV);
    else if (v < XW'(MINV)) return DW'(MINV);
    else                    return v[DW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] scale(
    input logic        [DW-1:0] a,
    input logic signed [DW-1:0] u,
    input logic signed [DW-1:0] m
  );
    logic signed [2*DW:0]  prod;
    logic signed [XW-1:0]  part;
    prod = $signed({1'b0, a}) * u;
    part = XW'(prod >>> (DW - 1));
    return clamp(part + XW'(m));
  endfunction

  function automatic logic signed [DW-1:0] ramp_step(
    input logic signed [DW-1:0] cur,
    input logic signed [DW-1:0] tgt,
    input logic        [DW-1:0] rate
  );
    logic signed [DW+1:0] c, t, r, n;
    c = (DW+2)'(cur);
    t = (DW+2)'(tgt);
    r = $signed({2'b00, rate});
    if (c < t) begin
      n = c + r;
      if (n > t) n = t;
    end else if (c > t) begin
      n = c - r;
      if (n < t) n = t;
    end else begin
      n = c;
    end
    return n[DW-1:0];
  endfunction

  logic signed [DW-1:0] nxt;

  always_comb begin
    unique case (mode)
      M_IDLE:  nxt = idle_lvl;
      M_SETPT: nxt = hold_lvl;
      M_RAMP:  nxt = ramp_step(sp_q, ramp_tgt, ramp_rate);
      default: nxt = scale(amp, unit, mean);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sp_q <= '0;
    else if (tick)  sp_q <= nxt;
  end

endmodule

// File: rtl/spgen_top.sv
module spgen_top
  import spgen_pkg::*;
#(
  parameter int PW = 32,
  parameter int DW = 16,
  parameter int QB = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [3:0]           mode_sel,
  input  logic        [DW-1:0] amp,
  input  logic signed [DW-1:0] mean,
  input  logic        [PW-1:0] freq_inc,
  input  logic signed [DW-1:0] idle_lvl,
  input  logic signed [DW-1:0] hold_lvl,
  input  logic signed [DW-1:0] ramp_tgt,
  input  logic        [DW-1:0] ramp_rate,
  output logic signed [DW-1:0] sp_out,
  output logic [3:0]           act_mode
);

  logic                 wrap;
  logic                 clear_ph;
  logic [DW-1:0]        ph_head;
  mode_e                mode_q;
  mode_e                mode_nxt;
  logic signed [DW-1:0] unit;
  logic signed [DW-1:0] sp_q;

  spgen_phase #(.PW(PW), .HW(DW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .inc     (freq_inc),
    .clear   (clear_ph),
    .wrap    (wrap),
    .ph_head (ph_head)
  );

  spgen_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .sel      (mode_sel),
    .wrap     (wrap),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt),
    .clear_ph (clear_ph)
  );

  spgen_shape #(.DW(DW), .QB(QB)) u_shape (
    .ph   (ph_head),
    .mode (mode_nxt),
    .unit (unit)
  );

  spgen_out #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode      (mode_nxt),
    .unit      (unit),
    .amp       (amp),
    .mean      (mean),
    .idle_lvl  (idle_lvl),
    .hold_lvl  (hold_lvl),
    .ramp_tgt  (ramp_tgt),
    .ramp_rate (ramp_rate),
    .sp_q      (sp_q)
  );

  assign sp_out   = sp_q;
  assign act_mode = mode_q;

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sp_out)); // R2

  AST_HAVER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && is_haver(mode_nxt)) |=> (sp_out >= $past(mean))); // R6

  AST_RAMP_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_nxt == M_RAMP && sp_out <= ramp_tgt)
      |=> (sp_out >= $past(sp_out)) && (sp_out <= $past(ramp_tgt))); // R8

endmodule

// File: tb/test_spgen_top.sv
module test_spgen_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n;
  logic               tick;
  logic [3:0]         mode_sel;
  logic [15:0]        amp;
  logic signed [15:0] mean;
  logic [31:0]        freq_inc;
  logic signed [15:0] idle_lvl;
  logic signed [15:0] hold_lvl;
  logic signed [15:0] ramp_tgt;
  logic [15:0]        ramp_rate;
  logic signed [15:0] sp_out;
  logic [3:0]         act_mode;

  spgen_top i_spgen_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel), .amp(amp),
    .mean(mean), .freq_inc(freq_inc), .idle_lvl(idle_lvl), .hold_lvl(hold_lvl),
    .ramp_tgt(ramp_tgt), .ramp_rate(ramp_rate), .sp_out(sp_out), .act_mode(act_mode)
  );

  int     n_cmp = 0;
  int     n_bad = 0;
  bit     done  = 0;
  longint m_ph;
  int     m_mode;
  int     m_out;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference arithmetic, written from the requirements.
  function automatic int qtab(input int x);
    return (32767 * x * (128 - x)) / 4096;
  endfunction

  function automatic int sine_ref(input longint p);
    int q = int'(p >> 30);
    int i = int'((p >> 24) & 63);
    int m = (q == 1 || q == 3) ? qtab(63 - i) : qtab(i);
    return (q >= 2) ? -m : m;
  endfunction

  function automatic int tri_ref(input longint p);
    int r = int'((p >> 16) & 32767);
    int m = (r >= 16384) ? 32767 - 2 * (r - 16384) : 2 * r;
    return ((p >> 31) & 1) != 0 ? -m : m;
  endfunction

  function automatic int sq_ref(input longint p);
    return ((p >> 31) & 1) != 0 ? -32767 : 32767;
  endfunction

  function automatic int clip(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int with_amp(input int b);
    longint pr = longint'(amp) * longint'(b);
    return clip(longint'(mean) + (pr >>> 15));
  endfunction

  function automatic int base_ref(input int md, input longint p);
    case (md)
      3, 6:    return sine_ref(p);
      4, 7:    return sq_ref(p);
      default: return tri_ref(p);
    endcase
  endfunction

  function automatic int wave_ref(input int md, input longint p);
    if (md >= 6) begin
      longint p2 = (p + (longint'(1) << 30)) & 64'hFFFF_FFFF;
      return with_amp((32767 - base_ref(md, p2)) / 2);
    end
    return with_amp(base_ref(md, p));
  endfunction

  function automatic int ramp_ref(input int cur);
    int t = int'(ramp_tgt);
    int r = int'(ramp_rate);
    if (cur < t) return (cur + r > t) ? t : cur + r;
    if (cur > t) return (cur - r < t) ? t : cur - r;
    return cur;
  endfunction

  function automatic string tag_of(input int md);
    case (md)
      0, 1:    return "R7";
      2:       return "R8";
      3:       return "R4";
      4, 5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic model_step();
    int     req  = (mode_sel > 8) ? 0 : int'(mode_sel);
    longint s    = m_ph + longint'(freq_inc);
    bit     carry = (s >> 32) != 0;
    longint nph  = s & 64'hFFFF_FFFF;
    bit     per  = (m_mode >= 3);
    if (req != m_mode && (req == 0 || !per || carry)) begin
      if (!per) nph = 0;
      m_mode = req;
    end
    m_ph = nph;
    case (m_mode)
      0:       m_out = int'(idle_lvl);
      1:       m_out = int'(hold_lvl);
      2:       m_out = ramp_ref(m_out);
      default: m_out = wave_ref(m_mode, m_ph);
    endcase
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      model_step();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      chk(tag_of(m_mode), int'(sp_out), m_out);
      chk("R9", int'(act_mode), m_mode);
      if (m_mode >= 6 && int'(sp_out) < int'(mean))
        chk("R6", int'(sp_out), int'(mean));
    end
  endtask

  task automatic quiet(input int n);
    repeat (n) @(negedge clk);
    chk("R2", int'(sp_out), m_out);
    chk("R2", int'(act_mode), m_mode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; mode_sel = 4'd0; amp = 16'd0; mean = 16'sd0;
    freq_inc = 32'd0; idle_lvl = 16'sd0; hold_lvl = 16'sd0;
    ramp_tgt = 16'sd0; ramp_rate = 16'd0;
    m_ph = 0; m_mode = 0; m_out = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(sp_out), 0);
    chk("R1", int'(act_mode), 0);
    rst_n = 1'b1;

    // Quiet cycles leave everything alone.
    idle_lvl = -16'sd1234;
    quiet(5);
    run_ticks(1);
    idle_lvl = 16'sd777;
    mode_sel = 4'd3;
    quiet(4);

    // Set point from idle takes effect at once.
    mode_sel = 4'd1; hold_lvl = 16'sd5000;
    run_ticks(2);

    // Fine sine sweep over every table entry.
    mode_sel = 4'd3; amp = 16'd20000; mean = 16'sd100; freq_inc = 32'h0100_0000;
    run_ticks(300);

    // Request made mid-period waits for the wrap.
    mode_sel = 4'd4; freq_inc = 32'h0123_4567;
    run_ticks(300);

    mode_sel = 4'd5; freq_inc = 32'h00C0_0000;
    run_ticks(420);

    amp = 16'd30000; mean = -16'sd500; freq_inc = 32'h0222_2222;
    mode_sel = 4'd6; run_ticks(200);
    mode_sel = 4'd7; run_ticks(200);
    mode_sel = 4'd8; run_ticks(200);

    // Idle request cuts in mid-period.
    mode_sel = 4'd0; idle_lvl = 16'sd777;
    run_ticks(1);
    chk("R9", int'(act_mode), 0);

    // Ramps up and down, landing on target.
    mode_sel = 4'd2; ramp_tgt = 16'sd3000; ramp_rate = 16'd700;
    run_ticks(8);
    chk("R8", int'(sp_out), 3000);
    ramp_tgt = -16'sd2000; ramp_rate = 16'd1000;
    run_ticks(8);
    chk("R8", int'(sp_out), -2000);

    // Both saturation limits.
    mode_sel = 4'd4; amp = 16'hFFFF; mean = 16'sd30000; freq_inc = 32'h8000_0000;
    run_ticks(1);
    chk("R10", int'(sp_out), 32767);
    run_ticks(1);
    chk("R10", int'(sp_out), -32768);
    run_ticks(6);

    // Unlisted code acts as idle.
    mode_sel = 4'd12; idle_lvl = -16'sd42;
    run_ticks(1);
    chk("R3", int'(act_mode), 0);
    chk("R3", int'(sp_out), -42);
    mode_sel = 4'd1; hold_lvl = 16'sd9;
    run_ticks(1);
    chk("R3", int'(act_mode), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule